// File: doc/BRIEF.md
# DRAM Precharge-Idle Time Monitor

This block sits beside a multi-bank DRAM controller and watches its command events. It measures how long the whole device spends with every bank precharged and no row open. Each idle gap starts when the last open bank closes, or when a refresh completes. The gap ends at the next activate. The controller supplies single-cycle event pulses, a tick timestamp, and the ready times it has already computed for the banks involved. The block keeps a count of open banks, a per-bank open mask and the start time of the current all-closed period. It adds every finished gap to a 64-bit idle total.

Alongside the idle total, the block counts read bytes served from the DRAM and read bytes forwarded from the write queue as two separate totals. It also counts write bytes, row hits and requests. A snapshot strobe copies every accumulator into shadow registers in a single cycle, so software always reads a consistent set. Software turns these raw totals into percentages and ratios; the block itself does no division.

Top module: `dram_idle_monitor`

## Requirements
- R1: On an activate, if the open-bank count (after any refresh and precharge of the same cycle) is zero and tick_i is strictly greater than the stored start time, the idle total grows by tick_i minus the start time. Otherwise the idle total is unchanged.
- R2: The page policy is encoded as 0 = open, 1 = open-adaptive and 2 = closed.
  - Under policies 0 and 1, an activate raises the open-bank count by one, saturating at N_BANKS, and sets bit act_bank_i of the open mask.
  - Under policy 2, an activate changes neither the count nor the mask.
- R3: An auto-precharge computes the bank ready time as max(pre_free_i, pre_ras_done_i) + T_RP. It lowers the count by one and clears bit pre_bank_i of the mask. When this brings the count to zero, the start time becomes max(start, ready time).
- R4: An auto-precharge while the count is zero leaves the count at zero and the start time unchanged, and sets a sticky error flag.
- R5: Under policy 2, an access pulse sets the start time to max(start, acc_ready_i). Under policies 0 and 1 the access pulse has no effect.
- R6: A refresh sets the start time to max(tick_i, ref_max_free_i) + T_RFC and clears the count and the open mask.
- R7: Events in one cycle apply in this order: refresh, then precharge, then activate, then access.
- R8: Each read-from-DRAM, read-from-write-queue and write pulse adds BURST_BYTES to its own counter. The snapshot also holds the sum of the two read counters.
- R9: The snapshot holds the row-hit numerator (read hits + write hits) and the denominator (read requests + write requests - requests serviced by the write queue).
- R10: snap_i copies every accumulator, as it stood before that edge, into the shadow outputs. Without snap_i the shadow outputs hold their values.
- R11: clear_i zeroes every accumulator and the error flag, and leaves the open-bank count, the mask and the start time intact. A snapshot taken in the same cycle captures the values from before the clear.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of accumulators and error flag |
| snap_i | input | 1 | Copy accumulators into shadow outputs |
| policy_i | input | 2 | Page policy: 0 open, 1 open-adaptive, 2 closed |
| tick_i | input | TICK_W | Current tick timestamp |
| act_i | input | 1 | Activate event |
| act_bank_i | input | BANK_W | Bank being activated |
| pre_i | input | 1 | Auto-precharge after a bank conflict |
| pre_bank_i | input | BANK_W | Bank being precharged |
| pre_free_i | input | TICK_W | Current ready time of the precharged bank |
| pre_ras_done_i | input | TICK_W | Time at which the bank's minimum active time ends |
| ref_i | input | 1 | Refresh event |
| ref_max_free_i | input | TICK_W | Latest ready time over all banks |
| acc_i | input | 1 | Access completed under the closed policy |
| acc_ready_i | input | TICK_W | Ready time of the accessed bank |
| rd_dram_i | input | 1 | Read burst served from DRAM |
| rd_wrq_i | input | 1 | Read burst forwarded from the write queue |
| wr_i | input | 1 | Write burst |
| rd_hit_i | input | 1 | Read row hit |
| wr_hit_i | input | 1 | Write row hit |
| rd_req_i | input | 1 | Read request |
| wr_req_i | input | 1 | Write request |
| wrq_serv_i | input | 1 | Request serviced by the write queue |
| active_cnt_o | output | CNT_BW | Open-bank count |
| open_mask_o | output | N_BANKS | One bit per open bank |
| start_tick_o | output | TICK_W | Start time of the all-closed period |
| err_o | output | 1 | Sticky precharge-at-zero error |
| snap_idle_o | output | ACC_W | Shadow idle total |
| snap_rd_dram_o | output | ACC_W | Shadow DRAM read bytes |
| snap_rd_wrq_o | output | ACC_W | Shadow write-queue read bytes |
| snap_rd_total_o | output | ACC_W | Shadow total read bytes |
| snap_wr_o | output | ACC_W | Shadow write bytes |
| snap_hits_o | output | ACC_W | Shadow row-hit numerator |
| snap_hit_base_o | output | ACC_W | Shadow row-hit denominator |

## Verification
The bench builds the block with N_BANKS = 4, T_RP = 3, T_RFC = 20 and BURST_BYTES = 32. With four banks, a handful of activates drives the open-bank count into saturation. The small timing constants keep every expected ready time and idle gap easy to work out by hand. The runs include:
- refresh and activate in the same cycle, to check that the refresh is applied first;
- precharge and activate in the same cycle, to check that the precharge is applied first;
- an activate landing exactly on the start time, which must add nothing to the idle total;
- a precharge while the count is zero, which must set the error flag.

// File: rtl/dram_idle_pkg.sv
package dram_idle_pkg;
  typedef enum logic [1:0] {
    POL_OPEN   = 2'd0,
    POL_ADAPT  = 2'd1,
    POL_CLOSED = 2'd2
  } page_pol_e;

  localparam int NUM_CTR = 8;
  // counter slots; first three are byte counters
  localparam int C_RD_DRAM  = 0;
  localparam int C_RD_WRQ   = 1;
  localparam int C_WR       = 2;
  localparam int C_RD_HIT   = 3;
  localparam int C_WR_HIT   = 4;
  localparam int C_RD_REQ   = 5;
  localparam int C_WR_REQ   = 6;
  localparam int C_WRQ_SERV = 7;
endpackage

// File: rtl/dim_bank_track.sv
module dim_bank_track
  import dram_idle_pkg::*;
#(
  parameter int N_BANKS = 8,
  localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int CNT_BW = $clog2(N_BANKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [1:0]        policy_i,
  input  logic              ref_i,
  input  logic              pre_i,
  input  logic [BANK_W-1:0] pre_bank_i,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  output logic [CNT_BW-1:0] cnt_q_o,
  output logic [CNT_BW-1:0] cnt_mid_o,
  output logic              closed_by_pre_o,
  output logic [N_BANKS-1:0] mask_q_o,
  output logic              err_q_o
);
  logic [CNT_BW-1:0]  cnt_q, c1, c2, c3;
  logic [N_BANKS-1:0] mask_q, m1, m2, m3;
  logic               err_q, bad, open_pol;

  always_comb begin
    open_pol = (policy_i != POL_CLOSED);
    c1 = ref_i ? '0 : cnt_q;
    m1 = ref_i ? '0 : mask_q;
    bad = pre_i && (c1 == '0);
    c2 = (pre_i && c1 != '0) ? c1 - 1'b1 : c1;
    closed_by_pre_o = pre_i && (c1 == CNT_BW'(1));
    m2 = m1;
    if (pre_i) m2[pre_bank_i] = 1'b0;
    c3 = c2;
    m3 = m2;
    if (act_i && open_pol) begin
      if (c2 != CNT_BW'(N_BANKS)) c3 = c2 + 1'b1;
      m3[act_bank_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= c3;
      mask_q <= m3;
      err_q  <= clear_i ? 1'b0 : (err_q | bad);
    end
  end

  assign cnt_q_o   = cnt_q;
  assign cnt_mid_o = c2;
  assign mask_q_o  = mask_q;
  assign err_q_o   = err_q;
endmodule

// File: rtl/dim_idle_acc.sv
module dim_idle_acc
  import dram_idle_pkg::*;
#(
  parameter int TICK_W = 48,
  parameter int ACC_W  = 64,
  parameter int CNT_BW = 4,
  parameter int T_RP   = 14,
  parameter int T_RFC  = 260
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [1:0]        policy_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              ref_i,
  input  logic [TICK_W-1:0] ref_max_free_i,
  input  logic              closed_by_pre_i,
  input  logic [TICK_W-1:0] pre_free_i,
  input  logic [TICK_W-1:0] pre_ras_done_i,
  input  logic              act_i,
  input  logic [CNT_BW-1:0] cnt_mid_i,
  input  logic              acc_i,
  input  logic [TICK_W-1:0] acc_ready_i,
  output logic [TICK_W-1:0] start_q_o,
  output logic [ACC_W-1:0]  idle_q_o
);
  logic [TICK_W-1:0] start_q, s1, s2, s3, rdy, rfree, gap;
  logic [ACC_W-1:0]  idle_q;
  logic              add_gap;

  always_comb begin
    rfree = (tick_i > ref_max_free_i) ? tick_i : ref_max_free_i;
    s1 = ref_i ? rfree + TICK_W'(T_RFC) : start_q;
    rdy = ((pre_free_i > pre_ras_done_i) ? pre_free_i : pre_ras_done_i) + TICK_W'(T_RP);
    s2 = (closed_by_pre_i && rdy > s1) ? rdy : s1;
    add_gap = act_i && (cnt_mid_i == '0) && (tick_i > s2);
    gap = tick_i - s2;
    s3 = (acc_i && policy_i == POL_CLOSED && acc_ready_i > s2) ? acc_ready_i : s2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      idle_q  <= '0;
    end else begin
      start_q <= s3;
      if (clear_i)      idle_q <= '0;
      else if (add_gap) idle_q <= idle_q + ACC_W'(gap);
    end
  end

  assign start_q_o = start_q;
  assign idle_q_o  = idle_q;
endmodule

// File: rtl/dim_stat_ctr.sv
module dim_stat_ctr #(
  parameter int W    = 64,
  parameter int STEP = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (inc_i)   cnt_o <= cnt_o + W'(STEP);
  end
endmodule

// File: rtl/dram_idle_monitor.sv
module dram_idle_monitor
  import dram_idle_pkg::*;
#(
  parameter int N_BANKS     = 8,
  parameter int TICK_W      = 48,
  parameter int ACC_W       = 64,
  parameter int T_RP        = 14,
  parameter int T_RFC       = 260,
  parameter int BURST_BYTES = 64,
  localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int CNT_BW = $clog2(N_BANKS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               snap_i,
  input  logic [1:0]         policy_i,
  input  logic [TICK_W-1:0]  tick_i,
  input  logic               act_i,
  input  logic [BANK_W-1:0]  act_bank_i,
  input  logic               pre_i,
  input  logic [BANK_W-1:0]  pre_bank_i,
  input  logic [TICK_W-1:0]  pre_free_i,
  input  logic [TICK_W-1:0]  pre_ras_done_i,
  input  logic               ref_i,
  input  logic [TICK_W-1:0]  ref_max_free_i,
  input  logic               acc_i,
  input  logic [TICK_W-1:0]  acc_ready_i,
  input  logic               rd_dram_i,
  input  logic               rd_wrq_i,
  input  logic               wr_i,
  input  logic               rd_hit_i,
  input  logic               wr_hit_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic               wrq_serv_i,
  output logic [CNT_BW-1:0]  active_cnt_o,
  output logic [N_BANKS-1:0] open_mask_o,
  output logic [TICK_W-1:0]  start_tick_o,
  output logic               err_o,
  output logic [ACC_W-1:0]   snap_idle_o,
  output logic [ACC_W-1:0]   snap_rd_dram_o,
  output logic [ACC_W-1:0]   snap_rd_wrq_o,
  output logic [ACC_W-1:0]   snap_rd_total_o,
  output logic [ACC_W-1:0]   snap_wr_o,
  output logic [ACC_W-1:0]   snap_hits_o,
  output logic [ACC_W-1:0]   snap_hit_base_o
);
  logic [CNT_BW-1:0]  cnt_mid;
  logic               closed_by_pre;
  logic [ACC_W-1:0]   idle_q;
  logic [NUM_CTR-1:0] ev;
  logic [ACC_W-1:0]   ctr [NUM_CTR];

  dim_bank_track #(.N_BANKS(N_BANKS)) u_bank (
    .clk_i, .rst_ni, .clear_i, .policy_i, .ref_i, .pre_i, .pre_bank_i,
    .act_i, .act_bank_i,
    .cnt_q_o(active_cnt_o), .cnt_mid_o(cnt_mid),
    .closed_by_pre_o(closed_by_pre), .mask_q_o(open_mask_o), .err_q_o(err_o)
  );

  dim_idle_acc #(
    .TICK_W(TICK_W), .ACC_W(ACC_W), .CNT_BW(CNT_BW), .T_RP(T_RP), .T_RFC(T_RFC)
  ) u_idle (
    .clk_i, .rst_ni, .clear_i, .policy_i, .tick_i, .ref_i, .ref_max_free_i,
    .closed_by_pre_i(closed_by_pre), .pre_free_i, .pre_ras_done_i,
    .act_i, .cnt_mid_i(cnt_mid), .acc_i, .acc_ready_i,
    .start_q_o(start_tick_o), .idle_q_o(idle_q)
  );

  assign ev = {wrq_serv_i, wr_req_i, rd_req_i, wr_hit_i, rd_hit_i, wr_i, rd_wrq_i, rd_dram_i};

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam int STEP = (i <= C_WR) ? BURST_BYTES : 1;
    dim_stat_ctr #(.W(ACC_W), .STEP(STEP)) u_ctr (
      .clk_i, .rst_ni, .clear_i, .inc_i(ev[i]), .cnt_o(ctr[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_idle_o     <= '0;
      snap_rd_dram_o  <= '0;
      snap_rd_wrq_o   <= '0;
      snap_rd_total_o <= '0;
      snap_wr_o       <= '0;
      snap_hits_o     <= '0;
      snap_hit_base_o <= '0;
    end else if (snap_i) begin
      snap_idle_o     <= idle_q;
      snap_rd_dram_o  <= ctr[C_RD_DRAM];
      snap_rd_wrq_o   <= ctr[C_RD_WRQ];
      snap_rd_total_o <= ctr[C_RD_DRAM] + ctr[C_RD_WRQ];
      snap_wr_o       <= ctr[C_WR];
      snap_hits_o     <= ctr[C_RD_HIT] + ctr[C_WR_HIT];
      snap_hit_base_o <= ctr[C_RD_REQ] + ctr[C_WR_REQ] - ctr[C_WRQ_SERV];
    end
  end
endmodule

// File: rtl/dim_checker.sv
module dim_checker #(
  parameter int N_BANKS = 8,
  parameter int TICK_W  = 48,
  parameter int ACC_W   = 64,
  localparam int CNT_BW = $clog2(N_BANKS + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               snap_i,
  input logic [1:0]         policy_i,
  input logic               act_i,
  input logic               pre_i,
  input logic               ref_i,
  input logic [CNT_BW-1:0]  active_cnt_o,
  input logic [N_BANKS-1:0] open_mask_o,
  input logic [TICK_W-1:0]  start_tick_o,
  input logic               err_o,
  input logic [ACC_W-1:0]   snap_idle_o,
  input logic [ACC_W-1:0]   snap_hit_base_o
);
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_cnt_o <= CNT_BW'(N_BANKS));

  assert_closed_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && policy_i == 2'd2 && !ref_i && !pre_i) |=> $stable(active_cnt_o));

  assert_start_mono_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_i |=> start_tick_o >= $past(start_tick_o));

  assert_err_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !ref_i && active_cnt_o == '0 && !clear_i) |=> err_o);

  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> err_o);

  assert_ref_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i && !act_i) |=> (active_cnt_o == '0 && open_mask_o == '0));

  assert_snap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(snap_idle_o) && $stable(snap_hit_base_o)));

  assert_clear_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !err_o);
endmodule

bind dram_idle_monitor dim_checker #(
  .N_BANKS(N_BANKS), .TICK_W(TICK_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .snap_i(snap_i),
  .policy_i(policy_i), .act_i(act_i), .pre_i(pre_i), .ref_i(ref_i),
  .active_cnt_o(active_cnt_o), .open_mask_o(open_mask_o),
  .start_tick_o(start_tick_o), .err_o(err_o),
  .snap_idle_o(snap_idle_o), .snap_hit_base_o(snap_hit_base_o)
);

// File: tb/dram_idle_monitor_bench.sv
module dram_idle_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int TW = 48;
  localparam int AW = 64;
  localparam int BW = 2;
  localparam int CB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear, snap, act, pre, refr, acc;
  logic rd_dram, rd_wrq, wr, rd_hit, wr_hit, rd_req, wr_req, wrq_serv;
  logic [1:0] policy;
  logic [TW-1:0] tick, pre_free, pre_ras, ref_free, acc_ready;
  logic [BW-1:0] act_bank, pre_bank;
  logic [CB-1:0] cnt;
  logic [NB-1:0] mask;
  logic [TW-1:0] start;
  logic err;
  logic [AW-1:0] s_idle, s_rdd, s_rdq, s_rdt, s_wr, s_hits, s_base;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int          sel;
    logic [63:0] val;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_idle_monitor #(
    .N_BANKS(NB), .TICK_W(TW), .ACC_W(AW), .T_RP(3), .T_RFC(20), .BURST_BYTES(32)
  ) u_dram_idle_monitor (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .snap_i(snap), .policy_i(policy),
    .tick_i(tick), .act_i(act), .act_bank_i(act_bank), .pre_i(pre), .pre_bank_i(pre_bank),
    .pre_free_i(pre_free), .pre_ras_done_i(pre_ras), .ref_i(refr), .ref_max_free_i(ref_free),
    .acc_i(acc), .acc_ready_i(acc_ready), .rd_dram_i(rd_dram), .rd_wrq_i(rd_wrq), .wr_i(wr),
    .rd_hit_i(rd_hit), .wr_hit_i(wr_hit), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .wrq_serv_i(wrq_serv), .active_cnt_o(cnt), .open_mask_o(mask), .start_tick_o(start),
    .err_o(err), .snap_idle_o(s_idle), .snap_rd_dram_o(s_rdd), .snap_rd_wrq_o(s_rdq),
    .snap_rd_total_o(s_rdt), .snap_wr_o(s_wr), .snap_hits_o(s_hits), .snap_hit_base_o(s_base)
  );

  function automatic logic [63:0] pick(int sel);
    case (sel)
      0: return 64'(cnt);
      1: return 64'(mask);
      2: return 64'(start);
      3: return 64'(err);
      4: return s_idle;
      5: return s_rdd;
      6: return s_rdq;
      7: return s_rdt;
      8: return s_wr;
      9: return s_hits;
      default: return s_base;
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [63:0] got;
      e = sb.pop_front();
      got = pick(e.sel);
      n_cmp++;
      if (got !== e.val) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", e.req, e.sel, got, e.val);
      end
    end
  end

  task automatic expect_v(int sel, logic [63:0] val, string req);
    exp_t e;
    e.sel = sel; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle_inputs();
    clear = 0; snap = 0; act = 0; pre = 0; refr = 0; acc = 0;
    rd_dram = 0; rd_wrq = 0; wr = 0; rd_hit = 0; wr_hit = 0;
    rd_req = 0; wr_req = 0; wrq_serv = 0;
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_act(int t, int b);
    @(negedge clk);
    act = 1; tick = TW'(t); act_bank = BW'(b);
    edge_step();
  endtask

  task automatic do_pre(int b, int fr, int ras);
    @(negedge clk);
    pre = 1; pre_bank = BW'(b); pre_free = TW'(fr); pre_ras = TW'(ras);
    edge_step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    policy = 2'd0; tick = '0; act_bank = '0; pre_bank = '0;
    pre_free = '0; pre_ras = '0; ref_free = '0; acc_ready = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    expect_v(0, 0, "R12"); expect_v(2, 0, "R12"); expect_v(3, 0, "R12"); expect_v(4, 0, "R12");
    @(negedge clk);
    rst_n = 1;

    // R1 first activate after reset: gap 100 - 0
    do_act(100, 1);
    expect_v(0, 1, "R2"); expect_v(1, 4'b0010, "R2");
    do_act(110, 2);
    expect_v(0, 2, "R2");
    // R3 precharge not reaching zero keeps start
    do_pre(1, 120, 125);
    expect_v(0, 1, "R3"); expect_v(2, 0, "R3"); expect_v(1, 4'b0100, "R3");
    // R3 ready = max(140,130)+3 = 143
    do_pre(2, 140, 130);
    expect_v(0, 0, "R3"); expect_v(2, 143, "R3"); expect_v(1, 0, "R3");
    // R1 gap 200-143 -> idle 157
    do_act(200, 0);
    // R2 saturation at 4
    do_act(201, 1); do_act(202, 2); do_act(203, 3); do_act(204, 3);
    expect_v(0, 4, "R2"); expect_v(1, 4'b1111, "R2");

    // R6/R7 refresh then activate same cycle: start = 310+20 = 330, act at 300 adds nothing
    @(negedge clk);
    refr = 1; ref_free = 310; tick = 300; act = 1; act_bank = 0;
    edge_step();
    expect_v(2, 330, "R6"); expect_v(0, 1, "R7"); expect_v(1, 4'b0001, "R7");

    do_pre(0, 340, 335);
    expect_v(2, 343, "R3"); expect_v(0, 0, "R3");
    // R4 precharge at zero
    do_pre(2, 999, 999);
    expect_v(3, 1, "R4"); expect_v(0, 0, "R4"); expect_v(2, 343, "R4");
    // R1 activate exactly at start: no gap
    do_act(343, 0);
    // R7 precharge then activate same cycle: start 353, gap 7 -> idle 164
    @(negedge clk);
    pre = 1; pre_bank = 0; pre_free = 350; pre_ras = 0;
    act = 1; tick = 360; act_bank = 1;
    edge_step();
    expect_v(2, 353, "R7"); expect_v(0, 1, "R7"); expect_v(1, 4'b0010, "R7");
    do_pre(1, 370, 0);
    expect_v(2, 373, "R3");

    // R5 closed policy
    policy = 2'd2;
    @(negedge clk);
    act = 1; tick = 400; acc = 1; acc_ready = 420;
    edge_step();
    expect_v(0, 0, "R2"); expect_v(2, 420, "R5"); expect_v(1, 0, "R2");
    @(negedge clk);
    act = 1; tick = 410; acc = 1; acc_ready = 430;
    edge_step();
    expect_v(2, 430, "R5");
    @(negedge clk);
    act = 1; tick = 450; acc = 1; acc_ready = 460;
    edge_step();
    expect_v(2, 460, "R5");
    // R5 access ignored under open-adaptive; R1 gap 40 -> idle 251
    policy = 2'd1;
    @(negedge clk);
    act = 1; tick = 500; act_bank = 2; acc = 1; acc_ready = 600;
    edge_step();
    expect_v(2, 460, "R5"); expect_v(0, 1, "R2"); expect_v(1, 4'b0100, "R2");

    // R10 shadow not yet loaded
    expect_v(4, 0, "R10");

    // R8/R9 counters
    @(negedge clk);
    rd_dram = 1; rd_wrq = 1; wr = 1; rd_hit = 1; wr_hit = 1; rd_req = 1; wr_req = 1; wrq_serv = 1;
    edge_step();
    @(negedge clk);
    rd_dram = 1; rd_wrq = 1; rd_hit = 1; rd_req = 1; wr_req = 1;
    edge_step();
    @(negedge clk);
    rd_dram = 1; rd_req = 1;
    edge_step();
    @(negedge clk);
    snap = 1;
    edge_step();
    expect_v(4, 251, "R1"); expect_v(5, 96, "R8"); expect_v(6, 64, "R8");
    expect_v(7, 160, "R8"); expect_v(8, 32, "R8"); expect_v(9, 3, "R9"); expect_v(10, 4, "R9");

    // R11 clear with snapshot in the same cycle
    @(negedge clk);
    clear = 1; snap = 1;
    edge_step();
    expect_v(4, 251, "R11"); expect_v(10, 4, "R11"); expect_v(3, 0, "R11");
    expect_v(0, 1, "R11"); expect_v(2, 460, "R11");
    @(negedge clk);
    snap = 1;
    edge_step();
    expect_v(4, 0, "R11"); expect_v(7, 0, "R11"); expect_v(10, 0, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule